// File: doc/BRIEF.md
# Iterative Bit-Clearing Population Counter

This block counts the set bits of a wide data word by repeatedly clearing the least significant set bit of a private working copy, one bit per clock. A single subtract-and-mask stage is reused every cycle, so the area stays near one wide decrement. The cost is a latency that grows with the number of ones in the word.

A caller presents a word and a threshold and pulses `start` while `busy` is low. The block then runs until its working copy is empty. It raises `done` for one cycle and leaves the bit count on `count`. The `over_thr` output reports whether that count is strictly above the threshold that was captured together with the word. Both outputs hold until the next accepted start.

Top module: `bitclear_popcount`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `count` is 0, `over_thr` is 0, `done` is 0 and `busy` is 0.
- R2: A `start` seen on a rising edge while `busy` is low captures `data_in` and `threshold`. From the next cycle, `busy` is 1, `count` is 0 and `over_thr` is 0.
- R3: At completion, `count` equals the number of ones in the captured word. This covers the full range 0 to DATA_W, so 0 to 256 with the defaults.
- R4: `done` is high in exactly the cycle that lies N+1 clock edges after the accepting edge, where N is the number of ones. An all-zero word therefore finishes one cycle after start, and an all-ones 256-bit word finishes 257 cycles after start. `busy` falls in the same cycle that `done` rises.
- R5: `done` lasts one cycle. Afterwards `count` and `over_thr` keep their values until the next accepted start.
- R6: `over_thr` is 1 exactly when the running count is strictly greater than the captured threshold. Once it is set during a run, it stays set for the rest of that run.
- R7: A `start` while `busy` is high has no effect. The result and the completion cycle of the run in progress are unchanged.
- R8: While busy, `count` rises by exactly one per clock cycle until the word is empty. It then stays unchanged in the completion cycle.
- R9: Changes on `threshold` or `data_in` after the accepting edge do not affect the run in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to capture `data_in` and `threshold`; honoured only while idle |
| data_in | input | DATA_W (256) | Word whose ones are counted |
| threshold | input | CNT_W (9) | Comparison level for `over_thr` |
| count | output | CNT_W (9) | Running count, final once `done` pulses |
| over_thr | output | 1 | Count strictly greater than the captured threshold |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | High while the clearing loop runs |

## Verification
The hardest case to reach from the ports is a second `start` that arrives mid-run carrying a different word. If the design honoured it, the result would change, so the bench injects an all-ones word a couple of cycles into a short run and still expects the original count and completion cycle. A threshold that drops to zero during a run exercises the capture rule in the same way. The full-width all-ones word is driven once so that the 257-cycle completion and the count of 256 are observed, both at threshold 255 and at threshold 256, on either side of the strict comparison.

// File: rtl/bitclear_pkg.sv
package bitclear_pkg;

  typedef enum logic {
    BC_IDLE = 1'b0,
    BC_RUN  = 1'b1
  } bc_state_t;

endpackage

// File: rtl/bc_lowbit_clear.sv
// Removes the least significant set bit of a word and reports an empty word.
module bc_lowbit_clear #(
  parameter int WIDTH = 256
) (
  input  logic [WIDTH-1:0] word_in,
  output logic [WIDTH-1:0] word_out,
  output logic             is_empty
);

  logic [WIDTH-1:0] dec;

  always_comb begin
    dec      = word_in - {{(WIDTH-1){1'b0}}, 1'b1};
    word_out = word_in & dec;
    is_empty = (word_in == '0);
  end

endmodule

// File: rtl/bc_step_counter.sv
// Count register with captured threshold and registered comparison flag.
module bc_step_counter #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic [CNT_W-1:0] thr_in,
  output logic [CNT_W-1:0] count_q,
  output logic             flag_q
);

  logic [CNT_W-1:0] thr_q;
  logic [CNT_W-1:0] count_inc;

  always_comb begin
    count_inc = count_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      thr_q   <= '0;
      flag_q  <= 1'b0;
    end else if (load) begin
      count_q <= '0;
      thr_q   <= thr_in;
      flag_q  <= 1'b0;
    end else if (step) begin
      count_q <= count_inc;
      flag_q  <= (count_inc > thr_q);
    end
  end

endmodule

// File: rtl/bitclear_popcount.sv
module bitclear_popcount #(
  parameter  int DATA_W = 256,
  localparam int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] data_in,
  input  logic [CNT_W-1:0]  threshold,
  output logic [CNT_W-1:0]  count,
  output logic              over_thr,
  output logic              done,
  output logic              busy
);

  import bitclear_pkg::*;

  bc_state_t         state_q;
  logic [DATA_W-1:0] work_q;
  logic [DATA_W-1:0] work_nxt;
  logic              work_empty;
  logic              load;
  logic              step;
  logic              done_q;

  bc_lowbit_clear #(.WIDTH(DATA_W)) u_clear (
    .word_in  (work_q),
    .word_out (work_nxt),
    .is_empty (work_empty)
  );

  always_comb begin
    load = (state_q == BC_IDLE) && start;
    step = (state_q == BC_RUN) && !work_empty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= BC_IDLE;
      work_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        BC_IDLE: begin
          if (start) begin
            work_q  <= data_in;
            state_q <= BC_RUN;
          end
        end
        BC_RUN: begin
          if (work_empty) begin
            state_q <= BC_IDLE;
            done_q  <= 1'b1;
          end else begin
            work_q <= work_nxt;
          end
        end
        default: state_q <= BC_IDLE;
      endcase
    end
  end

  bc_step_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .step    (step),
    .thr_in  (threshold),
    .count_q (count),
    .flag_q  (over_thr)
  );

  always_comb begin
    done = done_q;
    busy = (state_q == BC_RUN);
  end

endmodule

// File: rtl/bitclear_popcount_chk.sv
module bitclear_popcount_chk #(
  parameter int DATA_W = 256,
  parameter int CNT_W  = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [CNT_W-1:0] count,
  input logic             over_thr,
  input logic             done,
  input logic             busy
);

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (count == '0) && !over_thr && !done && !busy); // R1

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy && (count == '0) && !over_thr); // R2

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DATA_W)); // R3

  AST_END_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R5

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(count) && $stable(over_thr)); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (busy && over_thr) |=> over_thr); // R6

  AST_BUSY_STEP: assert property (@(posedge clk) disable iff (rst)
    busy |=> (done && $stable(count)) || (count == $past(count) + 1'b1)); // R8

endmodule

bind bitclear_popcount bitclear_popcount_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .count    (count),
  .over_thr (over_thr),
  .done     (done),
  .busy     (busy)
);

// File: tb/sim_bitclear_popcount.sv
`timescale 1ns/1ps
module sim_bitclear_popcount;

  localparam int W  = 256;
  localparam int CW = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [W-1:0]  data_in = '0;
  logic [CW-1:0] threshold = '0;
  logic [CW-1:0] count;
  logic          over_thr;
  logic          done;
  logic          busy;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bitclear_popcount #(.DATA_W(W)) u0 (
    .clk(clk), .rst(rst), .start(start), .data_in(data_in),
    .threshold(threshold), .count(count), .over_thr(over_thr),
    .done(done), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ones(input logic [W-1:0] w);
    int n = 0;
    for (int i = 0; i < W; i++) n += int'(w[i]);
    return n;
  endfunction

  // inj_at: cycle of a start carrying all ones while busy (R7)
  // thr_at: cycle at which threshold is forced to 0 (R9)
  task automatic run(input logic [W-1:0] w, input int th, input int inj_at,
                     input int thr_at, input bit trace);
    int n;
    int exp_n;
    bit exp_f;
    exp_n = ones(w);
    exp_f = (exp_n > th);
    @(negedge clk);
    data_in = w; threshold = CW'(th); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && count == 0 && !over_thr, "R2", "busy/count/flag after start",
        int'(busy) + int'(count) * 2 + int'(over_thr) * 4096, 1);
    n = 0;
    while (!done && n < 400) begin
      if (n == inj_at) begin start = 1'b1; data_in = '1; end
      else start = 1'b0;
      if (n == thr_at) begin threshold = '0; data_in = '1; end
      @(negedge clk);
      n++;
      if (trace && !done)
        chk(int'(count) == n, "R8", "running count", int'(count), n);
    end
    start = 1'b0;
    chk(n == exp_n + 1, "R4", "completion cycle", n, exp_n + 1);
    chk(!busy, "R4", "busy at done", int'(busy), 0);
    chk(int'(count) == exp_n, (inj_at >= 0) ? "R7" : "R3", "count",
        int'(count), exp_n);
    chk(over_thr == exp_f, (thr_at >= 0) ? "R9" : "R6", "flag",
        int'(over_thr), int'(exp_f));
    @(negedge clk);
    chk(!done && int'(count) == exp_n && over_thr == exp_f, "R5",
        "hold after done", int'(done) * 1000 + int'(count), exp_n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] pat;
    repeat (3) @(negedge clk);
    chk(count == 0 && !over_thr && !done && !busy, "R1", "outputs in reset",
        int'(count) + int'(over_thr) + int'(done) + int'(busy), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(count == 0 && !over_thr && !done && !busy, "R1", "outputs after reset",
        int'(count) + int'(over_thr) + int'(done) + int'(busy), 0);

    // R3 R4 R6: sweep every 8-bit value at shifting positions and thresholds
    for (int v = 0; v < 256; v++) begin
      pat = W'(v) << ((v % 32) * 7);
      run(pat, v % 10, -1, -1, 1'b0);
    end

    // R4 R3: all-zero word, then the full-width word on both sides of the compare
    run('0, 0, -1, -1, 1'b0);
    run('1, 255, -1, -1, 1'b0);
    run('1, 256, -1, -1, 1'b0);
    // R6: single top bit against threshold 0 and 1
    run({1'b1, {(W-1){1'b0}}}, 0, -1, -1, 1'b0);
    run({1'b1, {(W-1){1'b0}}}, 1, -1, -1, 1'b0);
    // R6: half-populated word across the strict boundary
    pat = '0;
    for (int i = 0; i < W; i += 2) pat[i] = 1'b1;
    run(pat, 127, -1, -1, 1'b0);
    run(pat, 128, -1, -1, 1'b0);
    // R8: per-cycle count trace
    run(W'(32'h8100_0A01), 3, -1, -1, 1'b1);
    // R7: start with a different word while busy
    run(W'(64'h0000_0100_2000_0103), 2, 2, -1, 1'b0);
    // R9: threshold and data changed mid-run
    run(W'(32'h0F00_0003), 5, -1, 1, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule